// File: doc/BRIEF.md
# Color Palette Host Access Port

This block sits between a host processor bus and a 256-entry color lookup palette in which each entry holds 8-bit red, green and blue values. The host sees four byte-wide registers: an address for loading the palette, an address for reading it back, a data port, and a control register. Color bytes pass through three holding registers. Writes gather a full triple before it is committed to the palette. Reads prefetch a full triple so that the host can drain it one byte at a time. After each complete triple the palette address steps up by one and wraps from 255 to 0.

The host can work in a narrow 6-bit color mode, which is the reset default, or in the full 8-bit mode. In narrow mode the 6 host bits map onto the top of each stored 8-bit value. This translation takes place only at the host boundary, and the holding registers always keep full 8-bit values. A status option replaces the readback of the read-mode address with a code that shows which address register was written last. The palette itself is an inferred register array. The pixel-side lookup is not part of this block.

Top module: `pal_port`

## Requirements
- R1: After reset, the control register reads 0x00 (6-bit mode, status off), both address registers read 0x00, the byte phase is red and rdata_o is 0x00.
- R2: A write to select 0 (write-mode address) loads the palette address. Each group of three writes to select 1 (data) stores red, green and blue at that address on the third byte and then increments the address, with 255 wrapping to 0.
- R3: A write to select 3 (read-mode address) loads the holding registers at once from the entry at the written address and sets the palette address to that value plus one.
- R4: Reads of select 1 return red, green and blue in that order. On the third read the entry at the current address is fetched into the holding registers and the address increments, so continuous reads walk ascending entries across the 255-to-0 wrap.
- R5: With control bit 0 clear (6-bit mode), host data bits [5:0] are stored in bits [7:2], stored bits [1:0] become 00, and host bits [7:6] are ignored.
- R6: In 6-bit mode, a data read returns stored bits [7:2] on bits [5:0] with bits [7:6] at 00. The holding registers keep all 8 bits, so changing to 8-bit mode in the middle of a triple returns the full value.
- R7: With control bit 1 clear, reads of select 0 and of select 3 both return the current palette address. Select 2 reads back the control bits.
- R8: With control bit 1 set, a read of select 3 returns 0x00 if the last address write went to select 0, and 0x03 if it went to select 3.
- R9: Any address write, in either mode, resets the byte phase to red. A partial write or read triple is abandoned.
- R10: rdata_o changes only at the clock edge that ends a read strobe (cs_i and rd_i high), and it holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe, takes priority over rd_i |
| sel_i | input | 2 | Register select: 0 write address, 1 data, 2 control, 3 read address |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data, valid the cycle after a read strobe |

## Verification
The data path is exercised with four patterns. The first writes triples in 8-bit mode and reads them back in 8-bit mode, which establishes the ordering and the address stepping. The second rereads the same entries in 6-bit mode and switches to 8-bit mode in the middle of a triple, which separates host-side translation from translation applied at storage. The third writes in 6-bit mode with bits set in [7:6], which shows that those bits are dropped and the low stored bits are zero. The fourth writes and reads a triple at address 255 and continues past it, which exposes a missing wrap or a fetch made at the wrong address. Address rewrites in the middle of a triple and status readback after each address mode separate phase handling from mode tracking.

// File: rtl/pal_port_pkg.sv
package pal_port_pkg;
  typedef enum logic [1:0] {
    SEL_WADDR = 2'd0,
    SEL_DATA  = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_RADDR = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  localparam int CTRL_RES8_BIT = 0;
  localparam int CTRL_STAT_BIT = 1;
  localparam logic [7:0] STAT_WMODE = 8'h00;
  localparam logic [7:0] STAT_RMODE = 8'h03;
  localparam int NUM_COMP = 3;
endpackage

// File: rtl/pal_decode.sv
module pal_decode
  import pal_port_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int COLOR_W  = 8,
  parameter int NARROW_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [1:0]         sel_i,
  input  logic [COLOR_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [COLOR_W-1:0] hold_byte_i,
  input  logic               rmode_i,
  output logic               waddr_we_o,
  output logic               raddr_we_o,
  output logic               data_we_o,
  output logic               data_re_o,
  output logic [COLOR_W-1:0] wr_byte_o,
  output logic [COLOR_W-1:0] rdata_o
);
  localparam int SHIFT_W = COLOR_W - NARROW_W;

  logic res8_q, stat_q;
  logic wr_en, rd_en;
  logic [COLOR_W-1:0] rd_mux;

  assign wr_en = cs_i & wr_i;
  assign rd_en = cs_i & rd_i & ~wr_i;

  assign waddr_we_o = wr_en & (reg_sel_e'(sel_i) == SEL_WADDR);
  assign raddr_we_o = wr_en & (reg_sel_e'(sel_i) == SEL_RADDR);
  assign data_we_o  = wr_en & (reg_sel_e'(sel_i) == SEL_DATA);
  assign data_re_o  = rd_en & (reg_sel_e'(sel_i) == SEL_DATA);

  // narrow host value lands in the top bits of the stored color
  assign wr_byte_o = res8_q ? wdata_i : {wdata_i[NARROW_W-1:0], {SHIFT_W{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res8_q <= 1'b0;
      stat_q <= 1'b0;
    end else if (wr_en && reg_sel_e'(sel_i) == SEL_CTRL) begin
      res8_q <= wdata_i[CTRL_RES8_BIT];
      stat_q <= wdata_i[CTRL_STAT_BIT];
    end
  end

  always_comb begin
    case (reg_sel_e'(sel_i))
      SEL_WADDR: rd_mux = COLOR_W'(addr_i);
      SEL_DATA:  rd_mux = res8_q ? hold_byte_i
                                 : COLOR_W'(hold_byte_i[COLOR_W-1 -: NARROW_W]);
      SEL_CTRL:  rd_mux = COLOR_W'({stat_q, res8_q});
      default:   rd_mux = stat_q ? (rmode_i ? COLOR_W'(STAT_RMODE) : COLOR_W'(STAT_WMODE))
                                 : COLOR_W'(addr_i);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (rd_en) rdata_o <= rd_mux;
  end

  AST_NARROW_TOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_re_o && !res8_q) |=> (rdata_o[COLOR_W-1 -: SHIFT_W] == '0)); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en |=> $stable(rdata_o)); // R10
  AST_STATUS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && stat_q && reg_sel_e'(sel_i) == SEL_RADDR)
      |=> (rdata_o == COLOR_W'(STAT_WMODE) || rdata_o == COLOR_W'(STAT_RMODE))); // R8
endmodule

// File: rtl/pal_seq.sv
module pal_seq
  import pal_port_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int COLOR_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               waddr_we_i,
  input  logic               raddr_we_i,
  input  logic               data_we_i,
  input  logic               data_re_i,
  input  logic [COLOR_W-1:0] wdata_i,
  output logic [ADDR_W-1:0]  addr_o,
  output phase_e             phase_o,
  output logic               rmode_o,
  output logic               commit_o,
  output logic               fetch_o,
  output logic [ADDR_W-1:0]  fetch_addr_o
);
  phase_e            phase_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rmode_q;
  logic              last_byte;
  logic [ADDR_W-1:0] new_addr;

  assign new_addr     = wdata_i[ADDR_W-1:0];
  assign last_byte    = (phase_q == PH_BLU);
  assign commit_o     = data_we_i & last_byte;
  assign fetch_o      = raddr_we_i | (data_re_i & last_byte);
  assign fetch_addr_o = raddr_we_i ? new_addr : addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      phase_q <= PH_RED;
      rmode_q <= 1'b0;
    end else if (waddr_we_i) begin
      addr_q  <= new_addr;
      phase_q <= PH_RED;
      rmode_q <= 1'b0;
    end else if (raddr_we_i) begin
      addr_q  <= new_addr + ADDR_W'(1);
      phase_q <= PH_RED;
      rmode_q <= 1'b1;
    end else if (data_we_i || data_re_i) begin
      if (last_byte) begin
        phase_q <= PH_RED;
        addr_q  <= addr_q + ADDR_W'(1);
      end else begin
        phase_q <= phase_e'(phase_q + 2'd1);
      end
    end
  end

  assign addr_o  = addr_q;
  assign phase_o = phase_q;
  assign rmode_o = rmode_q;

  AST_PHASE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q != 2'd3); // R4
  AST_WRITE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> (addr_q == $past(addr_q) + ADDR_W'(1))); // R2
  AST_READ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_re_i && last_byte) |=> (addr_q == $past(addr_q) + ADDR_W'(1))); // R4
  AST_RADDR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raddr_we_i |=> (addr_q == $past(new_addr) + ADDR_W'(1))); // R3
  AST_PHASE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (waddr_we_i || raddr_we_i) |=> (phase_q == PH_RED)); // R9
  AST_MODE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raddr_we_i |=> rmode_q); // R8
  AST_MODE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    waddr_we_i |=> !rmode_q); // R8
endmodule

// File: rtl/pal_store.sv
module pal_store
  import pal_port_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int COLOR_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               data_we_i,
  input  phase_e             phase_i,
  input  logic [COLOR_W-1:0] wr_byte_i,
  input  logic               commit_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               fetch_i,
  input  logic [ADDR_W-1:0]  fetch_addr_i,
  output logic [COLOR_W-1:0] hold_byte_o
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = NUM_COMP * COLOR_W;

  logic [WORD_W-1:0]  mem_q [DEPTH];
  logic [COLOR_W-1:0] hold_q [NUM_COMP];
  logic [WORD_W-1:0]  fetch_word;

  assign fetch_word = mem_q[fetch_addr_i];

  // red in the top lane, blue in the bottom
  always_ff @(posedge clk_i) begin
    if (commit_i) mem_q[addr_i] <= {hold_q[0], hold_q[1], wr_byte_i};
  end

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_hold
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        hold_q[c] <= '0;
      else if (fetch_i)
        hold_q[c] <= fetch_word[(NUM_COMP-1-c)*COLOR_W +: COLOR_W];
      else if (data_we_i && phase_i == phase_e'(c))
        hold_q[c] <= wr_byte_i;
    end
  end

  always_comb begin
    case (phase_i)
      PH_GRN:  hold_byte_o = hold_q[1];
      PH_BLU:  hold_byte_o = hold_q[2];
      default: hold_byte_o = hold_q[0];
    endcase
  end

  AST_NO_FETCH_ON_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fetch_i && commit_i)); // R2
endmodule

// File: rtl/pal_port.sv
module pal_port
  import pal_port_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int COLOR_W  = 8,
  parameter int NARROW_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [1:0]         sel_i,
  input  logic [COLOR_W-1:0] wdata_i,
  output logic [COLOR_W-1:0] rdata_o
);
  logic               waddr_we, raddr_we, data_we, data_re;
  logic [COLOR_W-1:0] wr_byte, hold_byte;
  logic [ADDR_W-1:0]  addr, fetch_addr;
  phase_e             phase;
  logic               rmode, commit, fetch;

  pal_decode #(.ADDR_W(ADDR_W), .COLOR_W(COLOR_W), .NARROW_W(NARROW_W)) u_decode (
    .clk_i, .rst_ni, .cs_i, .rd_i, .wr_i, .sel_i, .wdata_i,
    .addr_i(addr), .hold_byte_i(hold_byte), .rmode_i(rmode),
    .waddr_we_o(waddr_we), .raddr_we_o(raddr_we), .data_we_o(data_we), .data_re_o(data_re),
    .wr_byte_o(wr_byte), .rdata_o
  );

  pal_seq #(.ADDR_W(ADDR_W), .COLOR_W(COLOR_W)) u_seq (
    .clk_i, .rst_ni,
    .waddr_we_i(waddr_we), .raddr_we_i(raddr_we), .data_we_i(data_we), .data_re_i(data_re),
    .wdata_i,
    .addr_o(addr), .phase_o(phase), .rmode_o(rmode),
    .commit_o(commit), .fetch_o(fetch), .fetch_addr_o(fetch_addr)
  );

  pal_store #(.ADDR_W(ADDR_W), .COLOR_W(COLOR_W)) u_store (
    .clk_i, .rst_ni,
    .data_we_i(data_we), .phase_i(phase), .wr_byte_i(wr_byte),
    .commit_i(commit), .addr_i(addr),
    .fetch_i(fetch), .fetch_addr_i(fetch_addr),
    .hold_byte_o(hold_byte)
  );
endmodule

// File: tb/sim_pal_port.sv
`timescale 1ns/1ps
module sim_pal_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rd_seen = 1'b0;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  pal_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rd_i(rd), .wr_i(wr),
    .sel_i(sel), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] s, input logic [7:0] d);
    cs = 1'b1; wr = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] s, input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    cs = 1'b1; rd = 1'b1; sel = s;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  // monitor: compare the value launched by the strobe seen at the last edge
  always @(posedge clk) rd_seen <= cs & rd & ~wr;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL scoreboard: unexpected read data %02h expected none", rdata);
      end else begin
        chk(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got hung expected finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rdata, 8'h00, "R1 rdata after reset");
    bus_read(2'd0, 8'h00, "R1 write address");
    bus_read(2'd3, 8'h00, "R1 read address");
    bus_read(2'd2, 8'h00, "R1 control");

    // R2 8-bit writes of two triples
    bus_write(2'd2, 8'h01);
    bus_write(2'd0, 8'h10);
    bus_write(2'd1, 8'h12); bus_write(2'd1, 8'h34); bus_write(2'd1, 8'h56);
    bus_write(2'd1, 8'h9A); bus_write(2'd1, 8'hBC); bus_write(2'd1, 8'hDE);
    bus_read(2'd0, 8'h12, "R2 address after two triples");
    // R3 R4 readback in order
    bus_write(2'd3, 8'h10);
    bus_read(2'd3, 8'h11, "R3 address after read-mode load");
    bus_read(2'd1, 8'h12, "R3 red prefetched");
    bus_read(2'd1, 8'h34, "R4 green");
    bus_read(2'd1, 8'h56, "R4 blue");
    bus_read(2'd1, 8'h9A, "R4 next red");
    bus_read(2'd1, 8'hBC, "R4 next green");
    bus_read(2'd1, 8'hDE, "R4 next blue");
    bus_read(2'd3, 8'h13, "R4 address after two fetches");
    // R10 hold without strobe
    @(negedge clk);
    chk(rdata, 8'h13, "R10 rdata held while idle");

    // R6 6-bit readback of 8-bit data, switch width mid triple
    bus_write(2'd2, 8'h00);
    bus_write(2'd3, 8'h10);
    bus_read(2'd1, 8'h04, "R6 narrow red");
    bus_read(2'd1, 8'h0D, "R6 narrow green");
    bus_read(2'd1, 8'h15, "R6 narrow blue");
    bus_read(2'd1, 8'h26, "R6 narrow next red");
    bus_write(2'd2, 8'h01);
    bus_read(2'd1, 8'hBC, "R6 full green kept in holding");
    bus_read(2'd1, 8'hDE, "R6 full blue kept in holding");

    // R5 6-bit writes
    bus_write(2'd2, 8'h00);
    bus_write(2'd0, 8'h20);
    bus_write(2'd1, 8'hFF); bus_write(2'd1, 8'h01); bus_write(2'd1, 8'h80);
    bus_write(2'd2, 8'h01);
    bus_write(2'd3, 8'h20);
    bus_read(2'd1, 8'hFC, "R5 top bits dropped, low zero");
    bus_read(2'd1, 8'h04, "R5 shift into upper bits");
    bus_read(2'd1, 8'h00, "R5 bits 7:6 ignored");

    // R2 R4 wrap at 255
    bus_write(2'd0, 8'hFF);
    bus_write(2'd1, 8'h11); bus_write(2'd1, 8'h22); bus_write(2'd1, 8'h33);
    bus_write(2'd1, 8'h44); bus_write(2'd1, 8'h55); bus_write(2'd1, 8'h66);
    bus_read(2'd0, 8'h01, "R2 address wrapped");
    bus_write(2'd3, 8'hFF);
    bus_read(2'd1, 8'h11, "R4 entry 255 red");
    bus_read(2'd1, 8'h22, "R4 entry 255 green");
    bus_read(2'd1, 8'h33, "R4 entry 255 blue");
    bus_read(2'd1, 8'h44, "R4 entry 0 red after wrap");
    bus_read(2'd1, 8'h55, "R4 entry 0 green");
    bus_read(2'd1, 8'h66, "R4 entry 0 blue");

    // R9 address writes abandon partial triples
    bus_write(2'd0, 8'h30);
    bus_write(2'd1, 8'hA1); bus_write(2'd1, 8'hA2);
    bus_write(2'd0, 8'h30);
    bus_write(2'd1, 8'h01); bus_write(2'd1, 8'h02); bus_write(2'd1, 8'h03);
    bus_read(2'd0, 8'h31, "R9 write phase restarted");
    bus_write(2'd3, 8'h30);
    bus_read(2'd1, 8'h01, "R9 red after rewrite");
    bus_write(2'd3, 8'h30);
    bus_read(2'd1, 8'h01, "R9 read phase restarted");
    bus_read(2'd1, 8'h02, "R9 green follows");

    // R7 R8 status readback
    bus_write(2'd2, 8'h03);
    bus_write(2'd0, 8'h40);
    bus_read(2'd3, 8'h00, "R8 status after write-mode address");
    bus_read(2'd0, 8'h40, "R7 write address unaffected by status");
    bus_write(2'd3, 8'h40);
    bus_read(2'd3, 8'h03, "R8 status after read-mode address");
    bus_read(2'd2, 8'h03, "R7 control readback");
    bus_write(2'd2, 8'h01);
    bus_read(2'd3, 8'h41, "R7 read address without status");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    summary();
  end
endmodule